// File: doc/BRIEF.md
# SD Host Command Issue and Inhibit Tracker

This block sits between the register file of an SD host controller and the serialiser that drives the card's command line. Software writes a 32-bit argument and then a 16-bit command word. The write to the command word is what starts a command. The block decodes the command word and checks whether the command line, or the data line, is still held by an earlier command. If neither is held, it hands the command to the serialiser through a one-cycle start strobe. It collects the response bits that the serialiser returns, and it stores the response in four 32-bit response words.

The block tracks two inhibit flags. The command inhibit covers the time from issue until the response has arrived. The data inhibit covers commands that use the data line: those that carry a data phase, and those whose short response is followed by a busy period on the card. The block reports two completion events. Command complete fires when the response ends. Transfer complete fires when the data phase or the busy period ends.

A three-bit self-clearing reset register lets software clear the command path, the data path, or both. Clearing both also wipes the argument and the stored response.

Top module: `sdc_cmd_tracker`

## Requirements
- R1: The command word has this layout:
  - bits 13:8 carry the index;
  - bits 7:6 carry the type, where 3 means abort;
  - bit 5 marks a data phase;
  - bit 4 enables the index check;
  - bit 3 enables the CRC check;
  - bits 1:0 give the response kind: 0 none, 1 long 136-bit, 2 short 48-bit, 3 short with busy.

  An accepted write drives `ser_start` high for exactly the cycle after the write edge. In that cycle the decoded fields appear on the `ser_*` outputs.
- R2: `ser_arg` carries the argument held at the moment of issue. Argument writes made while a command is running do not change it.
- R3: The command inhibit sets at the write edge of an accepted command. It clears at the edge that samples `ser_done`, and `evt_cmd_done` pulses for the one cycle that follows that edge.
- R4: An accepted command sets the data inhibit if it has a data phase or response kind 3. Any other command leaves the data inhibit untouched.
- R5: A command write has no effect in two cases:
  - the command inhibit is set;
  - the command needs the data line, the data inhibit is set, and the type is not abort.
- R6: An abort-type command needs only the command line to be free. If its response kind is 3, its busy wait replaces any pending data-phase wait, so a `dat_done` pulse no longer clears the data inhibit.
- R7: For response kind 3 with no data phase, the data inhibit stays set after command complete for as long as `card_busy` is high. It clears together with an `evt_xfer_done` pulse once `card_busy` is sampled low.
- R8: For a command with a data phase, a `dat_done` pulse clears the data inhibit and pulses `evt_xfer_done` in the following cycle.
- R9: A short response, kinds 2 and 3, stores bits 39:8 of the 48-bit token in word 0 and leaves words 1 to 3 unchanged. Kind 0 changes no word.
- R10: A long response stores bits 127:8 of the 136-bit token across the four words, right-aligned. Word 0 takes the lowest 32 bits, and bits 31:24 of word 3 read 0.
- R11: Writing reset bit 1 has these effects:
  - the command inhibit clears at that same edge;
  - the running command is abandoned, with no `evt_cmd_done` even when `ser_done` arrives in that cycle;
  - the response words are not changed;
  - `ser_abort` is high while the reset is in progress.
- R12: Writing reset bit 2 clears the data inhibit without `evt_xfer_done`. Writing reset bit 0 clears both paths and sets the argument and all four response words to 0.
- R13: Written reset bits read back on `srst_state` for exactly RST_CYCLES cycles and then clear themselves. While a command-path reset is in progress, command writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arg_wr | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument write data |
| cmd_wr | input | 1 | Command word write strobe; starts a command |
| cmd_wdata | input | 16 | Command word write data |
| srst_wr | input | 1 | Software reset register write strobe |
| srst_wdata | input | 3 | Reset request: bit 0 all, bit 1 command path, bit 2 data path |
| srst_state | output | 3 | Reset bits still in progress |
| ser_start | output | 1 | One-cycle start strobe to the serialiser |
| ser_abort | output | 1 | Serialiser must drop the current command |
| ser_index | output | 6 | Index of the issued command |
| ser_arg | output | 32 | Argument of the issued command |
| ser_resp_type | output | 2 | Response kind of the issued command |
| ser_idx_chk | output | 1 | Index check enabled for the response |
| ser_crc_chk | output | 1 | CRC check enabled for the response |
| ser_data | output | 1 | Issued command has a data phase |
| resp_bit_vld | input | 1 | A response token bit is present |
| resp_bit | input | 1 | Response token bit, most significant first |
| ser_done | input | 1 | Serialiser finished the command and its response |
| card_busy | input | 1 | Card holds the data line busy |
| dat_done | input | 1 | Data phase finished (from the data mover) |
| inhibit_cmd | output | 1 | Command line inhibit |
| inhibit_dat | output | 1 | Data line inhibit |
| evt_cmd_done | output | 1 | Command complete pulse |
| evt_xfer_done | output | 1 | Transfer complete pulse |
| resp_w0 | output | 32 | Response word 0 |
| resp_w1 | output | 32 | Response word 1 |
| resp_w2 | output | 32 | Response word 2 |
| resp_w3 | output | 32 | Response word 3 |

## Verification
The response finishing and a command-path reset can land on the same clock edge. The bench provokes this by raising `ser_done` and a reset write with bit 1 in the same cycle. It judges the result by four observations: there is no command complete event, the command inhibit is already low, `ser_abort` is high, and the response words keep their old values. A second collision is a command write arriving while the earlier command's busy period or data phase still holds the data line. That write must be dropped unless it is an abort, and an abort must take over the data wait. Random commands with random tokens check response storage against a bench model.

// File: rtl/sdc_cmd_pkg.sv
`timescale 1ns/1ps
// Shared widths, field positions and types for the command tracker.
// Assumes the command-word layout that software and the serialiser agree on.
package sdc_cmd_pkg;
    localparam int CMD_W      = 16;
    localparam int ARG_W      = 32;
    localparam int IDX_W      = 6;
    localparam int WORD_W     = 32;
    localparam int RESP_WORDS = 4;
    localparam int SRST_W     = 3;
    // Token bit positions kept in the response words
    localparam int SHORT_HI   = 39;
    localparam int SHORT_LO   = 8;
    localparam int LONG_HI    = 127;
    localparam int LONG_LO    = 8;
    localparam int TOK_W      = LONG_HI + 1;
    localparam int RESP_W     = RESP_WORDS * WORD_W;

    typedef enum logic [1:0] {
        RSP_NONE       = 2'd0,
        RSP_LONG       = 2'd1,
        RSP_SHORT      = 2'd2,
        RSP_SHORT_BUSY = 2'd3
    } rsp_kind_e;

    typedef struct packed {
        logic [IDX_W-1:0] index;
        logic             abort;
        logic             data;
        logic             idx_chk;
        logic             crc_chk;
        rsp_kind_e        rsp;
    } cmd_fields_t;

    typedef enum logic [1:0] {
        DW_IDLE,
        DW_XFER,
        DW_BUSY_PEND,
        DW_BUSY
    } dat_wait_e;
endpackage

// File: rtl/sdc_srst_seq.sv
`timescale 1ns/1ps
// Self-clearing software reset register.
// Each written bit stays visible for RST_CYCLES cycles. A second write
// while a reset is in progress adds its bits and restarts the count.
// The clear outputs take effect at the write edge itself, so a path is
// already quiet in the cycle of the write. Assumes RST_CYCLES >= 1.
module sdc_srst_seq
    import sdc_cmd_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [SRST_W-1:0] wdata,
    output logic [SRST_W-1:0] active,
    output logic              clr_all,
    output logic              clr_cmd,
    output logic              clr_dat
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             req_any;

    assign req_any = wr & (|wdata);

    // Hold the requested bits and count down the reset duration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
            cnt_q  <= '0;
        end else if (req_any) begin
            active <= active | wdata;
            cnt_q  <= CNT_W'(RST_CYCLES - 1);
        end else if (|active) begin
            if (cnt_q == '0) begin
                active <= '0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Path clears: either a reset in progress or a request this cycle
    always_comb begin
        clr_all = active[0] | (wr & wdata[0]);
        clr_cmd = clr_all | active[1] | (wr & wdata[1]);
        clr_dat = clr_all | active[2] | (wr & wdata[2]);
    end
endmodule

// File: rtl/sdc_cmd_path.sv
`timescale 1ns/1ps
// Command path: admission check, issue, and wait for the response.
// The command inhibit is the waiting flag. It is set by an accepted
// write and cleared by ser_done or by a command-path clear. The clear
// wins over a ser_done in the same cycle. Assumes the serialiser raises
// ser_done only after the start strobe.
module sdc_cmd_path
    import sdc_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_cmd,
    input  logic             cmd_wr,
    input  cmd_fields_t      fields,
    input  logic [ARG_W-1:0] arg_q,
    input  logic             inhibit_dat,
    input  logic             ser_done,
    output logic             issue,
    output logic             wait_rsp,
    output logic             done_now,
    output logic             cmd_done,
    output logic             ser_start,
    output cmd_fields_t      cur,
    output logic [ARG_W-1:0] cur_arg
);
    logic needs_dat;

    // Decide whether the written command may start now
    always_comb begin
        needs_dat = fields.data | (fields.rsp == RSP_SHORT_BUSY);
        issue     = cmd_wr & ~clr_cmd & ~wait_rsp
                  & (~needs_dat | ~inhibit_dat | fields.abort);
        done_now  = wait_rsp & ser_done & ~clr_cmd;
    end

    // Track the command in flight and produce start and complete pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_rsp  <= 1'b0;
            ser_start <= 1'b0;
            cmd_done  <= 1'b0;
            cur       <= '0;
            cur_arg   <= '0;
        end else begin
            ser_start <= 1'b0;
            cmd_done  <= 1'b0;
            if (clr_cmd) begin
                wait_rsp <= 1'b0;
            end else if (issue) begin
                wait_rsp  <= 1'b1;
                ser_start <= 1'b1;
                cur       <= fields;
                cur_arg   <= arg_q;
            end else if (done_now) begin
                wait_rsp <= 1'b0;
                cmd_done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdc_dat_path.sv
`timescale 1ns/1ps
// Data-line tracker: holds the data inhibit until the data phase or the
// card busy period ends.
// A busy wait starts only after command complete. It assumes card_busy
// is already valid in the cycle after that event. An abort with a busy
// response replaces whatever wait was pending.
module sdc_dat_path
    import sdc_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_dat,
    input  logic        issue,
    input  cmd_fields_t fields,
    input  logic        cmd_done,
    input  logic        card_busy,
    input  logic        dat_done,
    output logic        inhibit_dat,
    output logic        xfer_done
);
    dat_wait_e state_q;
    dat_wait_e start_state;
    logic      needs_dat;
    logic      is_busy;

    // Choose the wait a newly issued command puts on the data line
    always_comb begin
        is_busy     = (fields.rsp == RSP_SHORT_BUSY);
        needs_dat   = fields.data | is_busy;
        start_state = (is_busy && (fields.abort || !fields.data)) ? DW_BUSY_PEND : DW_XFER;
    end

    // Step the data-line wait and raise transfer complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= DW_IDLE;
            xfer_done <= 1'b0;
        end else begin
            xfer_done <= 1'b0;
            if (clr_dat) begin
                state_q <= DW_IDLE;
            end else if (issue && needs_dat) begin
                state_q <= start_state;
            end else begin
                case (state_q)
                    DW_XFER: begin
                        if (dat_done) begin
                            state_q   <= DW_IDLE;
                            xfer_done <= 1'b1;
                        end
                    end
                    DW_BUSY_PEND: begin
                        if (cmd_done) state_q <= DW_BUSY;
                    end
                    DW_BUSY: begin
                        if (!card_busy) begin
                            state_q   <= DW_IDLE;
                            xfer_done <= 1'b1;
                        end
                    end
                    default: state_q <= DW_IDLE;
                endcase
            end
        end
    end

    assign inhibit_dat = (state_q != DW_IDLE);
endmodule

// File: rtl/sdc_resp_store.sv
`timescale 1ns/1ps
// Response capture and storage.
// Shifts in token bits most significant first while a response is
// awaited. When the command completes, it copies the payload into the
// response words according to the response kind. The CRC byte of a long
// token is dropped and the payload is right-aligned. A bit that arrives
// together with ser_done is included.
module sdc_resp_store
    import sdc_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              issue,
    input  logic              capture_en,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              commit,
    input  rsp_kind_e         rsp,
    output logic [RESP_W-1:0] resp_flat
);
    localparam int LONG_BITS = LONG_HI - LONG_LO + 1;

    logic [TOK_W-1:0] tok_q;
    logic [TOK_W-1:0] tok_nxt;

    // Next token contents including a bit arriving this cycle
    always_comb begin
        tok_nxt = tok_q;
        if (capture_en && bit_vld) tok_nxt = {tok_q[TOK_W-2:0], bit_in};
    end

    // Shift register and response words
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            tok_q     <= '0;
            resp_flat <= '0;
        end else begin
            tok_q <= issue ? '0 : tok_nxt;
            if (commit) begin
                case (rsp)
                    RSP_SHORT, RSP_SHORT_BUSY:
                        resp_flat[WORD_W-1:0] <= tok_nxt[SHORT_HI:SHORT_LO];
                    RSP_LONG:
                        resp_flat <= {{(RESP_W-LONG_BITS){1'b0}}, tok_nxt[LONG_HI:LONG_LO]};
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdc_cmd_tracker.sv
`timescale 1ns/1ps
// Top of the SD command issue and inhibit tracker.
// Decodes command writes, holds the argument, and connects the command
// path, the data-line tracker, the response store and the reset
// register. Assumes register writes arrive as single-cycle strobes.
module sdc_cmd_tracker
    import sdc_cmd_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arg_wr,
    input  logic [ARG_W-1:0]  arg_wdata,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              srst_wr,
    input  logic [SRST_W-1:0] srst_wdata,
    output logic [SRST_W-1:0] srst_state,
    output logic              ser_start,
    output logic              ser_abort,
    output logic [IDX_W-1:0]  ser_index,
    output logic [ARG_W-1:0]  ser_arg,
    output logic [1:0]        ser_resp_type,
    output logic              ser_idx_chk,
    output logic              ser_crc_chk,
    output logic              ser_data,
    input  logic              resp_bit_vld,
    input  logic              resp_bit,
    input  logic              ser_done,
    input  logic              card_busy,
    input  logic              dat_done,
    output logic              inhibit_cmd,
    output logic              inhibit_dat,
    output logic              evt_cmd_done,
    output logic              evt_xfer_done,
    output logic [WORD_W-1:0] resp_w0,
    output logic [WORD_W-1:0] resp_w1,
    output logic [WORD_W-1:0] resp_w2,
    output logic [WORD_W-1:0] resp_w3
);
    cmd_fields_t       dec;
    cmd_fields_t       cur;
    logic [ARG_W-1:0]  arg_q;
    logic              clr_all;
    logic              clr_cmd;
    logic              clr_dat;
    logic              issue;
    logic              wait_rsp;
    logic              done_now;
    logic [RESP_W-1:0] resp_flat;
    logic              unused_cmd_bits;

    // Split the written command word into its fields
    always_comb begin
        dec.index   = cmd_wdata[13:8];
        dec.abort   = (cmd_wdata[7:6] == 2'b11);
        dec.data    = cmd_wdata[5];
        dec.idx_chk = cmd_wdata[4];
        dec.crc_chk = cmd_wdata[3];
        dec.rsp     = rsp_kind_e'(cmd_wdata[1:0]);
    end
    assign unused_cmd_bits = ^{cmd_wdata[15:14], cmd_wdata[2]};

    // Argument register, wiped by a full reset
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            arg_q <= '0;
        end else if (arg_wr) begin
            arg_q <= arg_wdata;
        end
    end

    sdc_srst_seq #(
        .RST_CYCLES (RST_CYCLES)
    ) u_srst (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (srst_wr),
        .wdata   (srst_wdata),
        .active  (srst_state),
        .clr_all (clr_all),
        .clr_cmd (clr_cmd),
        .clr_dat (clr_dat)
    );

    sdc_cmd_path u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_cmd     (clr_cmd),
        .cmd_wr      (cmd_wr),
        .fields      (dec),
        .arg_q       (arg_q),
        .inhibit_dat (inhibit_dat),
        .ser_done    (ser_done),
        .issue       (issue),
        .wait_rsp    (wait_rsp),
        .done_now    (done_now),
        .cmd_done    (evt_cmd_done),
        .ser_start   (ser_start),
        .cur         (cur),
        .cur_arg     (ser_arg)
    );

    sdc_dat_path u_dat (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_dat     (clr_dat),
        .issue       (issue),
        .fields      (dec),
        .cmd_done    (evt_cmd_done),
        .card_busy   (card_busy),
        .dat_done    (dat_done),
        .inhibit_dat (inhibit_dat),
        .xfer_done   (evt_xfer_done)
    );

    sdc_resp_store u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all    (clr_all),
        .issue      (issue),
        .capture_en (wait_rsp),
        .bit_vld    (resp_bit_vld),
        .bit_in     (resp_bit),
        .commit     (done_now),
        .rsp        (cur.rsp),
        .resp_flat  (resp_flat)
    );

    // Outputs toward the serialiser and the register file
    always_comb begin
        inhibit_cmd   = wait_rsp;
        ser_abort     = clr_cmd;
        ser_index     = cur.index;
        ser_resp_type = cur.rsp;
        ser_idx_chk   = cur.idx_chk;
        ser_crc_chk   = cur.crc_chk;
        ser_data      = cur.data;
        resp_w0       = resp_flat[0*WORD_W +: WORD_W];
        resp_w1       = resp_flat[1*WORD_W +: WORD_W];
        resp_w2       = resp_flat[2*WORD_W +: WORD_W];
        resp_w3       = resp_flat[3*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/sdc_cmd_tracker_chk.sv
`timescale 1ns/1ps
// Protocol checker for the command tracker, attached by bind.
// It observes only top-level ports.
module sdc_cmd_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] srst_state,
    input logic       ser_start,
    input logic       inhibit_cmd,
    input logic       inhibit_dat,
    input logic       evt_cmd_done,
    input logic       evt_xfer_done
);
    // R1
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |=> !ser_start);

    // R5
    start_only_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |-> !$past(inhibit_cmd));

    // R3
    cmd_inhibit_rises_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inhibit_cmd) |-> ser_start);

    // R3
    done_frees_cmd_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_cmd_done |-> !inhibit_cmd);

    // R4
    dat_inhibit_rises_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inhibit_dat) |-> ser_start);

    // R7
    xfer_frees_dat_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_xfer_done |-> !inhibit_dat);

    // R11
    cmd_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_state[0] || srst_state[1]) |-> (!inhibit_cmd && !evt_cmd_done));

    // R12
    dat_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_state[0] || srst_state[2]) |-> (!inhibit_dat && !evt_xfer_done));
endmodule

bind sdc_cmd_tracker sdc_cmd_tracker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .srst_state    (srst_state),
    .ser_start     (ser_start),
    .inhibit_cmd   (inhibit_cmd),
    .inhibit_dat   (inhibit_dat),
    .evt_cmd_done  (evt_cmd_done),
    .evt_xfer_done (evt_xfer_done)
);

// File: tb/sdc_cmd_tracker_tb.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random commands.
module sdc_cmd_tracker_tb;
    localparam int RST = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         arg_wr = 1'b0;
    logic [31:0]  arg_wdata = '0;
    logic         cmd_wr = 1'b0;
    logic [15:0]  cmd_wdata = '0;
    logic         srst_wr = 1'b0;
    logic [2:0]   srst_wdata = '0;
    logic [2:0]   srst_state;
    logic         ser_start, ser_abort, ser_idx_chk, ser_crc_chk, ser_data;
    logic [5:0]   ser_index;
    logic [31:0]  ser_arg;
    logic [1:0]   ser_resp_type;
    logic         resp_bit_vld = 1'b0;
    logic         resp_bit = 1'b0;
    logic         ser_done = 1'b0;
    logic         card_busy = 1'b0;
    logic         dat_done = 1'b0;
    logic         inhibit_cmd, inhibit_dat, evt_cmd_done, evt_xfer_done;
    logic [31:0]  resp_w0, resp_w1, resp_w2, resp_w3;

    int           n_chk = 0;
    int           n_fail = 0;
    bit           finished = 1'b0;
    logic [127:0] exp_resp = '0;

    always #2 clk = ~clk;

    sdc_cmd_tracker #(.RST_CYCLES(RST)) u_dut (
        .clk(clk), .rst_n(rst_n), .arg_wr(arg_wr), .arg_wdata(arg_wdata),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .srst_wr(srst_wr),
        .srst_wdata(srst_wdata), .srst_state(srst_state), .ser_start(ser_start),
        .ser_abort(ser_abort), .ser_index(ser_index), .ser_arg(ser_arg),
        .ser_resp_type(ser_resp_type), .ser_idx_chk(ser_idx_chk),
        .ser_crc_chk(ser_crc_chk), .ser_data(ser_data), .resp_bit_vld(resp_bit_vld),
        .resp_bit(resp_bit), .ser_done(ser_done), .card_busy(card_busy),
        .dat_done(dat_done), .inhibit_cmd(inhibit_cmd), .inhibit_dat(inhibit_dat),
        .evt_cmd_done(evt_cmd_done), .evt_xfer_done(evt_xfer_done),
        .resp_w0(resp_w0), .resp_w1(resp_w1), .resp_w2(resp_w2), .resp_w3(resp_w3)
    );

    function automatic logic [15:0] cw(input logic [5:0] idx, input logic [1:0] typ,
                                       input logic dat, input logic ichk,
                                       input logic cchk, input logic [1:0] rsp);
        return {2'b00, idx, typ, dat, ichk, cchk, 1'b0, rsp};
    endfunction

    function automatic logic [127:0] model_resp(input logic [127:0] old,
                                                input logic [135:0] tok,
                                                input logic [1:0] rsp);
        case (rsp)
            2'd1:       return {8'h00, tok[127:8]};
            2'd2, 2'd3: return {old[127:32], tok[39:8]};
            default:    return old;
        endcase
    endfunction

    function automatic int tok_len(input logic [1:0] rsp);
        return (rsp == 2'd1) ? 136 : ((rsp == 2'd0) ? 0 : 48);
    endfunction

    function automatic logic [135:0] rnd_tok();
        return {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_cmd(input logic [15:0] w);
        cmd_wr = 1'b1; cmd_wdata = w; tick(); cmd_wr = 1'b0;
    endtask

    task automatic wr_arg(input logic [31:0] a);
        arg_wr = 1'b1; arg_wdata = a; tick(); arg_wr = 1'b0;
    endtask

    task automatic wr_srst(input logic [2:0] d);
        srst_wr = 1'b1; srst_wdata = d; tick(); srst_wr = 1'b0;
    endtask

    task automatic send_bits(input logic [135:0] tok, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            resp_bit_vld = 1'b1; resp_bit = tok[i]; tick();
        end
        resp_bit_vld = 1'b0;
    endtask

    // Feed a full token, then ser_done; checks completion at the port
    task automatic finish_cmd(input string tag, input logic [135:0] tok, input logic [1:0] rsp);
        send_bits(tok, tok_len(rsp));
        ser_done = 1'b1; tick(); ser_done = 1'b0;
        exp_resp = model_resp(exp_resp, tok, rsp);
        chk({tag, " R3 cmd done"}, evt_cmd_done, 1'b1);
        chk({tag, " R3 cmd inhibit"}, inhibit_cmd, 1'b0);
        chk({tag, " resp"}, {resp_w3, resp_w2, resp_w1, resp_w0}, exp_resp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [135:0] tok;
        logic [31:0]  a;
        logic [5:0]   idx;
        logic [1:0]   rsp;
        logic         ic, cc;
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // Reset state (R3, R4, R13)
        chk("R3 reset cmd inhibit", inhibit_cmd, 1'b0);
        chk("R4 reset dat inhibit", inhibit_dat, 1'b0);
        chk("R13 reset srst_state", srst_state, 3'b000);
        chk("R1 reset ser_start", ser_start, 1'b0);
        chk("R9 reset resp", {resp_w3, resp_w2, resp_w1, resp_w0}, 128'h0);

        // R1 R2: issue fields, argument latched at issue
        wr_arg(32'hA5A5_1234);
        wr_cmd(cw(6'd17, 2'd0, 1'b0, 1'b1, 1'b1, 2'd2));
        chk("R1 start", ser_start, 1'b1);
        chk("R1 index", ser_index, 6'd17);
        chk("R1 rsp type", ser_resp_type, 2'd2);
        chk("R1 checks", {ser_idx_chk, ser_crc_chk, ser_data}, 3'b110);
        chk("R2 arg", ser_arg, 32'hA5A5_1234);
        chk("R3 inhibit set", inhibit_cmd, 1'b1);
        chk("R4 no dat inhibit", inhibit_dat, 1'b0);
        wr_arg(32'h0BAD_F00D);
        chk("R1 start one cycle", ser_start, 1'b0);
        chk("R2 arg held", ser_arg, 32'hA5A5_1234);
        // R5: write while command in flight is dropped
        wr_cmd(cw(6'd40, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2));
        chk("R5 no start while busy", ser_start, 1'b0);
        chk("R5 index unchanged", ser_index, 6'd17);
        tok = rnd_tok();
        finish_cmd("R9 short", tok, 2'd2);
        tick();
        chk("R3 done one cycle", evt_cmd_done, 1'b0);

        // R10: long response
        wr_cmd(cw(6'd2, 2'd0, 1'b0, 1'b0, 1'b1, 2'd1));
        tok = rnd_tok();
        finish_cmd("R10 long", tok, 2'd1);

        // R7: busy response holds the data line
        card_busy = 1'b1;
        wr_cmd(cw(6'd7, 2'd0, 1'b0, 1'b1, 1'b1, 2'd3));
        chk("R4 busy sets dat inhibit", inhibit_dat, 1'b1);
        tok = rnd_tok();
        finish_cmd("R7 busy cmd", tok, 2'd3);
        repeat (4) tick();
        chk("R7 held while busy", inhibit_dat, 1'b1);
        chk("R7 no xfer while busy", evt_xfer_done, 1'b0);
        wr_cmd(cw(6'd18, 2'd0, 1'b1, 1'b1, 1'b1, 2'd2));
        chk("R5 data cmd dropped", ser_start, 1'b0);
        card_busy = 1'b0;
        tick();
        chk("R7 xfer done", evt_xfer_done, 1'b1);
        chk("R7 dat inhibit clear", inhibit_dat, 1'b0);

        // R8: data phase
        wr_cmd(cw(6'd18, 2'd0, 1'b1, 1'b1, 1'b1, 2'd2));
        chk("R4 data sets dat inhibit", inhibit_dat, 1'b1);
        tok = rnd_tok();
        finish_cmd("R8 data cmd", tok, 2'd2);
        chk("R8 dat inhibit after cmd", inhibit_dat, 1'b1);
        dat_done = 1'b1; tick(); dat_done = 1'b0;
        chk("R8 xfer done", evt_xfer_done, 1'b1);
        chk("R8 dat inhibit clear", inhibit_dat, 1'b0);

        // R6: abort with busy replaces pending data wait
        wr_cmd(cw(6'd25, 2'd0, 1'b1, 1'b1, 1'b1, 2'd2));
        tok = rnd_tok();
        finish_cmd("R6 data cmd", tok, 2'd2);
        card_busy = 1'b1;
        wr_cmd(cw(6'd12, 2'd3, 1'b0, 1'b1, 1'b1, 2'd3));
        chk("R6 abort accepted", ser_start, 1'b1);
        chk("R6 abort index", ser_index, 6'd12);
        dat_done = 1'b1; tick(); dat_done = 1'b0;
        chk("R6 dat_done ignored", evt_xfer_done, 1'b0);
        chk("R6 dat inhibit kept", inhibit_dat, 1'b1);
        tok = rnd_tok();
        finish_cmd("R6 abort", tok, 2'd3);
        tick();
        chk("R6 still busy", inhibit_dat, 1'b1);
        card_busy = 1'b0;
        tick();
        chk("R6 xfer after busy", evt_xfer_done, 1'b1);
        chk("R6 dat inhibit clear", inhibit_dat, 1'b0);

        // R11: command reset colliding with ser_done
        wr_cmd(cw(6'd9, 2'd0, 1'b0, 1'b1, 1'b1, 2'd2));
        tok = rnd_tok();
        send_bits(tok, 48);
        ser_done = 1'b1; srst_wr = 1'b1; srst_wdata = 3'b010;
        tick();
        ser_done = 1'b0; srst_wr = 1'b0;
        chk("R11 no cmd done", evt_cmd_done, 1'b0);
        chk("R11 cmd inhibit clear", inhibit_cmd, 1'b0);
        chk("R11 abort out", ser_abort, 1'b1);
        chk("R11 resp kept", {resp_w3, resp_w2, resp_w1, resp_w0}, exp_resp);
        chk("R13 state set", srst_state, 3'b010);
        wr_cmd(cw(6'd3, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0));
        chk("R13 write ignored in reset", ser_start, 1'b0);
        repeat (RST - 2) tick();
        chk("R13 state held", srst_state, 3'b010);
        tick();
        chk("R13 state self-clear", srst_state, 3'b000);
        chk("R11 abort released", ser_abort, 1'b0);

        // R12: data reset during busy
        card_busy = 1'b1;
        wr_cmd(cw(6'd7, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3));
        tok = rnd_tok();
        finish_cmd("R12 busy cmd", tok, 2'd3);
        tick(); tick();
        wr_srst(3'b100);
        chk("R12 dat inhibit cleared", inhibit_dat, 1'b0);
        chk("R12 no xfer event", evt_xfer_done, 1'b0);
        card_busy = 1'b0;
        repeat (RST + 1) tick();
        chk("R13 data bit self-clear", srst_state, 3'b000);

        // R12: full reset wipes argument and responses
        wr_arg(32'h1357_9BDF);
        wr_srst(3'b001);
        exp_resp = '0;
        chk("R12 resp wiped", {resp_w3, resp_w2, resp_w1, resp_w0}, 128'h0);
        chk("R12 inhibits clear", {inhibit_cmd, inhibit_dat}, 2'b00);
        repeat (RST + 1) tick();
        wr_cmd(cw(6'd13, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0));
        chk("R12 arg wiped", ser_arg, 32'h0);
        finish_cmd("R9 none", rnd_tok(), 2'd0);

        // Random commands with random tokens
        for (int it = 0; it < 40; it++) begin
            idx = 6'($urandom());
            rsp = 2'($urandom_range(0, 2));
            a   = $urandom();
            ic  = 1'($urandom());
            cc  = 1'($urandom());
            wr_arg(a);
            wr_cmd(cw(idx, 2'd0, 1'b0, ic, cc, rsp));
            chk("R1 rand start", ser_start, 1'b1);
            chk("R1 rand fields", {ser_index, ser_resp_type, ser_idx_chk, ser_crc_chk},
                {idx, rsp, ic, cc});
            chk("R2 rand arg", ser_arg, a);
            if ($urandom_range(0, 1) == 1) begin
                wr_cmd(cw(~idx, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2));
                chk("R5 rand drop", {ser_start, ser_index}, {1'b0, idx});
            end
            tok = rnd_tok();
            finish_cmd((rsp == 2'd1) ? "R10 rand" : "R9 rand", tok, rsp);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule